// File: doc/BRIEF.md
# Event Timer Main Counter and Global Registers

This block is the shared core of a multi-channel event timer. It owns the free-running 64-bit main counter, the global control bits, the per-channel interrupt status flags and a read-only capability description. Software reaches it through a simple 32-bit register port. The block decodes the register offset. Offsets in the global area are served locally. Offsets in the channel area are steered to the right channel block, which sits outside this core.

The counter advances by one on every cycle in which the tick enable input is high and the global enable bit is set. When the global enable bit is clear, the counter holds its value and software may load either 32-bit half of it. A 64-bit quantity is accessed as two 32-bit transfers, low half first. When the enable bit rises, every channel whose comparator is not at its all-ones idle value receives a one-cycle re-arm pulse. Channel blocks report expiry events into the status register. Software clears status bits by writing ones, and the core pulses an acknowledge line to the channel for each bit that is cleared.

Read data is registered: it appears on `reg_rdata` in the cycle after `reg_re` is sampled high, and it holds until the next read.

Top module: `evt_timer_core`

## Requirements
- R1: A read at offset 0x000 returns 0x8086A001 with (NUM_CH-1) placed in bits [12:8]. With NUM_CH=3 this is 0x8086A201.
- R2: A read at offset 0x004 returns the PERIOD_FS parameter. A write to offset 0x000 or 0x004 changes nothing.
- R3: The control register sits at offset 0x010. Only bits [1:0] are writable. All other bits read as 0, and reset clears the register to 0.
- R4: The counter increments by one on each clock edge at which control bit 0 (enable) is 1 and `tick_en` is 1. Otherwise it holds its value. It carries across the 32-bit boundary. `count_out` shows it directly.
- R5: While enable is 0, a write to offset 0x0F0 loads counter bits [31:0] and a write to offset 0x0F4 loads bits [63:32]. The other half is unchanged. While enable is 1, these writes are dropped. Reads at these offsets return the live counter.
- R6: The status register sits at offset 0x020 and has one bit per channel (bit n for channel n). While enable is 1, a high `ch_event[n]` sets bit n. Writing 1 to a bit clears it and gives a one-cycle `irq_ack[n]` pulse in the next cycle. Writing 0 has no effect. If a set and a clear hit the same bit in the same cycle, the set wins.
- R7: When enable falls from 1 to 0, all status bits are cleared and each bit that was set is acknowledged on `irq_ack`. While enable is 0, `ch_event` sets nothing.
- R8: Offsets 0x100 and above select channel n = (offset - 0x100) / 0x20. `ch_sel` is one-hot on channel n and `ch_sub` = offset[4:0]. `ch_we`, `ch_re` and `ch_wdata` follow the port in the same cycle. A read returns slice n of `ch_rdata`.
- R9: A reserved global offset, or a channel index of NUM_CH or more, reads as 0. A write to such an offset changes no register and raises no `ch_we` or `ch_sel` bit.
- R10: On the clock edge where a control write turns enable from 0 to 1, `ch_rearm[n]` is set for one cycle for every channel whose `ch_cmp_max[n]` is 0. No pulse appears when enable is written but does not rise.
- R11: After reset, the counter, control bits, status, `ch_rearm`, `irq_ack` and `reg_rdata` are all 0.
- R12: `legacy_route` is control bit 1 and `timer_enable` is control bit 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Counter advance strobe |
| reg_addr | input | 10 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_we | input | 1 | Write strobe |
| reg_re | input | 1 | Read strobe |
| reg_rdata | output | 32 | Registered read data |
| ch_sel | output | NUM_CH | One-hot channel window select |
| ch_sub | output | 5 | Register offset inside the channel window |
| ch_wdata | output | 32 | Write data to channels |
| ch_we | output | 1 | Channel write strobe |
| ch_re | output | 1 | Channel read strobe |
| ch_rdata | input | 32*NUM_CH | Per-channel read data, channel n in slice n |
| ch_cmp_max | input | NUM_CH | Channel comparator holds all ones |
| ch_event | input | NUM_CH | Channel expiry event |
| ch_rearm | output | NUM_CH | One-cycle re-arm pulse per channel |
| irq_ack | output | NUM_CH | One-cycle status-clear pulse per channel |
| count_out | output | 64 | Main counter value |
| timer_enable | output | 1 | Global enable bit |
| legacy_route | output | 1 | Legacy routing bit |

## Verification
Some properties are checked on every cycle. The counter either holds or steps by exactly one, according to enable and tick. No status bit appears while interrupts are disabled. A write-one clear or a disable leaves the affected status bits at zero. Re-arm pulses occur only on the first cycle of enable. The channel select is never more than one-hot. Other behaviour can only be shown by the bench's scenarios, because it depends on absolute values and on ordered access sequences: the capability words, the masked control write, loading one counter half while keeping the other, the carry between halves, writes dropped while enabled, the set-over-clear priority, the channel window arithmetic and the zero reads of unmapped offsets.

// File: rtl/evt_timer_pkg.sv
`timescale 1ns/1ps
package evt_timer_pkg;

  localparam int OFS_W      = 10;
  localparam int SUB_W      = 5;
  localparam int CHIDX_W    = OFS_W - SUB_W;
  localparam int CTRL_W     = 2;

  localparam logic [OFS_W-1:0] OFS_CAP_LO = 10'h000;
  localparam logic [OFS_W-1:0] OFS_CAP_HI = 10'h004;
  localparam logic [OFS_W-1:0] OFS_CTRL   = 10'h010;
  localparam logic [OFS_W-1:0] OFS_STAT   = 10'h020;
  localparam logic [OFS_W-1:0] OFS_CNT_LO = 10'h0F0;
  localparam logic [OFS_W-1:0] OFS_CNT_HI = 10'h0F4;
  localparam logic [OFS_W-1:0] OFS_CHBASE = 10'h100;

  localparam logic [31:0]       CAP_SIGNATURE = 32'h8086A001;
  localparam logic [CTRL_W-1:0] CTRL_WMASK    = 2'b11;

  typedef enum logic [2:0] {
    RK_NONE, RK_CAP_LO, RK_CAP_HI, RK_CTRL, RK_STAT, RK_CNT_LO, RK_CNT_HI, RK_CHAN
  } reg_kind_e;

  typedef struct packed {
    reg_kind_e          kind;
    logic [CHIDX_W-1:0] chan;
    logic [SUB_W-1:0]   sub;
  } reg_dec_t;

  // capability low word: signature with channel count minus one in [12:8]
  function automatic logic [31:0] cap_low_word(int nch);
    logic [31:0] n1;
    n1 = 32'(nch - 1) & 32'h1F;
    return CAP_SIGNATURE | (n1 << 8);
  endfunction

  // channel windows start at OFS_CHBASE, 32 bytes each
  function automatic reg_dec_t decode_offset(logic [OFS_W-1:0] ofs, int nch);
    reg_dec_t d;
    d.kind = RK_NONE;
    d.sub  = ofs[SUB_W-1:0];
    d.chan = ofs[OFS_W-1:SUB_W] - OFS_CHBASE[OFS_W-1:SUB_W];
    if (ofs >= OFS_CHBASE) begin
      if (32'(d.chan) < 32'(nch)) d.kind = RK_CHAN;
    end else begin
      case (ofs)
        OFS_CAP_LO: d.kind = RK_CAP_LO;
        OFS_CAP_HI: d.kind = RK_CAP_HI;
        OFS_CTRL:   d.kind = RK_CTRL;
        OFS_STAT:   d.kind = RK_STAT;
        OFS_CNT_LO: d.kind = RK_CNT_LO;
        OFS_CNT_HI: d.kind = RK_CNT_HI;
        default:    d.kind = RK_NONE;
      endcase
    end
    return d;
  endfunction

  function automatic logic [CTRL_W-1:0] masked_merge(logic [CTRL_W-1:0] nv,
                                                     logic [CTRL_W-1:0] ov,
                                                     logic [CTRL_W-1:0] m);
    return (nv & m) | (ov & ~m);
  endfunction

  function automatic logic [63:0] load_half(logic [63:0] cur, logic upper, logic [31:0] w);
    return upper ? {w, cur[31:0]} : {cur[63:32], w};
  endfunction

endpackage

// File: rtl/evt_addr_decode.sv
`timescale 1ns/1ps
module evt_addr_decode
  import evt_timer_pkg::*;
#(
  parameter int NUM_CH = 3
) (
  input  logic [OFS_W-1:0]  ofs,
  output reg_dec_t          dec,
  output logic [NUM_CH-1:0] sel
);
  assign dec = decode_offset(ofs, NUM_CH);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_sel
    assign sel[i] = (dec.kind == RK_CHAN) && (dec.chan == CHIDX_W'(i));
  end
endmodule

// File: rtl/evt_main_counter.sv
`timescale 1ns/1ps
module evt_main_counter #(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic             load_lo,
  input  logic             load_hi,
  input  logic [31:0]      wdata,
  output logic [CNT_W-1:0] count
);
  import evt_timer_pkg::*;

  always_ff @(posedge clk) begin
    if (!rst_n)       count <= '0;
    else if (load_lo) count <= load_half(count, 1'b0, wdata);
    else if (load_hi) count <= load_half(count, 1'b1, wdata);
    else if (run && tick) count <= count + CNT_W'(1);
  end

  // R4: frozen while disabled unless software loads a half
  p_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !load_lo && !load_hi) |=> $stable(count));

  // R4: steps by exactly one per enabled tick
  p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick && !load_lo && !load_hi) |=> count == $past(count) + CNT_W'(1));

  // R4: no movement without a tick
  p_notick_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load_lo && !load_hi) |=> $stable(count));
endmodule

// File: rtl/evt_irq_status.sv
`timescale 1ns/1ps
module evt_irq_status #(
  parameter int NUM_CH = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              gen_en,
  input  logic [NUM_CH-1:0] set_in,
  input  logic              clr_wr,
  input  logic [NUM_CH-1:0] clr_data,
  input  logic              flush,
  output logic [NUM_CH-1:0] stat,
  output logic [NUM_CH-1:0] ack
);
  logic [NUM_CH-1:0] set_eff;
  logic [NUM_CH-1:0] clr_eff;

  assign set_eff = gen_en ? set_in : '0;
  assign clr_eff = clr_wr ? clr_data : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat <= '0;
      ack  <= '0;
    end else if (flush) begin
      stat <= '0;
      ack  <= stat;
    end else begin
      stat <= (stat & ~clr_eff) | set_eff;
      ack  <= stat & clr_eff & ~set_eff;
    end
  end

  // R7: a disable leaves nothing pending
  p_flush_r7: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> stat == '0);

  // R7: no new status bit while generation is off
  p_noset_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !gen_en |=> (stat & ~$past(stat)) == '0);

  // R6: cleared bits without a competing set are zero afterwards
  p_w1c_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wr |=> (stat & $past(clr_data & ~set_eff)) == '0);

  // R6: acknowledge only bits that were pending
  p_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (ack & ~$past(stat)) == '0);
endmodule

// File: rtl/evt_timer_core.sv
`timescale 1ns/1ps
module evt_timer_core
  import evt_timer_pkg::*;
#(
  parameter int          NUM_CH    = 3,
  parameter logic [31:0] PERIOD_FS = 32'd10_000_000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick_en,
  input  logic [9:0]           reg_addr,
  input  logic [31:0]          reg_wdata,
  input  logic                 reg_we,
  input  logic                 reg_re,
  output logic [31:0]          reg_rdata,
  output logic [NUM_CH-1:0]    ch_sel,
  output logic [4:0]           ch_sub,
  output logic [31:0]          ch_wdata,
  output logic                 ch_we,
  output logic                 ch_re,
  input  logic [32*NUM_CH-1:0] ch_rdata,
  input  logic [NUM_CH-1:0]    ch_cmp_max,
  input  logic [NUM_CH-1:0]    ch_event,
  output logic [NUM_CH-1:0]    ch_rearm,
  output logic [NUM_CH-1:0]    irq_ack,
  output logic [63:0]          count_out,
  output logic                 timer_enable,
  output logic                 legacy_route
);
  localparam logic [31:0] CAP_LO = cap_low_word(NUM_CH);

  reg_dec_t          dec;
  logic [CTRL_W-1:0] ctrl_q;
  logic [CTRL_W-1:0] ctrl_next;
  logic              ctrl_wr;
  logic              en_rise_evt;
  logic              en_fall_evt;
  logic              cnt_load_lo;
  logic              cnt_load_hi;
  logic              stat_clr_wr;
  logic [NUM_CH-1:0] stat_q;
  logic [31:0]       rd_next;

  evt_addr_decode #(.NUM_CH(NUM_CH)) u_dec (
    .ofs (reg_addr),
    .dec (dec),
    .sel (ch_sel)
  );

  // channel window pass-through
  assign ch_sub   = dec.sub;
  assign ch_wdata = reg_wdata;
  assign ch_we    = reg_we && (dec.kind == RK_CHAN);
  assign ch_re    = reg_re && (dec.kind == RK_CHAN);

  // control register and its edge events
  assign ctrl_wr     = reg_we && (dec.kind == RK_CTRL);
  assign ctrl_next   = masked_merge(reg_wdata[CTRL_W-1:0], ctrl_q, CTRL_WMASK);
  assign en_rise_evt = ctrl_wr && !ctrl_q[0] &&  ctrl_next[0];
  assign en_fall_evt = ctrl_wr &&  ctrl_q[0] && !ctrl_next[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      ch_rearm <= '0;
    end else begin
      if (ctrl_wr) ctrl_q <= ctrl_next;
      ch_rearm <= en_rise_evt ? ~ch_cmp_max : '0;
    end
  end

  assign timer_enable = ctrl_q[0];
  assign legacy_route = ctrl_q[1];

  // counter halves load only while halted
  assign cnt_load_lo = reg_we && (dec.kind == RK_CNT_LO) && !ctrl_q[0];
  assign cnt_load_hi = reg_we && (dec.kind == RK_CNT_HI) && !ctrl_q[0];

  evt_main_counter #(.CNT_W(64)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (ctrl_q[0]),
    .tick    (tick_en),
    .load_lo (cnt_load_lo),
    .load_hi (cnt_load_hi),
    .wdata   (reg_wdata),
    .count   (count_out)
  );

  assign stat_clr_wr = reg_we && (dec.kind == RK_STAT);

  evt_irq_status #(.NUM_CH(NUM_CH)) u_stat (
    .clk      (clk),
    .rst_n    (rst_n),
    .gen_en   (ctrl_q[0]),
    .set_in   (ch_event),
    .clr_wr   (stat_clr_wr),
    .clr_data (reg_wdata[NUM_CH-1:0]),
    .flush    (en_fall_evt),
    .stat     (stat_q),
    .ack      (irq_ack)
  );

  // read mux
  always_comb begin
    rd_next = '0;
    case (dec.kind)
      RK_CAP_LO: rd_next = CAP_LO;
      RK_CAP_HI: rd_next = PERIOD_FS;
      RK_CTRL:   rd_next[CTRL_W-1:0] = ctrl_q;
      RK_STAT:   rd_next[NUM_CH-1:0] = stat_q;
      RK_CNT_LO: rd_next = count_out[31:0];
      RK_CNT_HI: rd_next = count_out[63:32];
      RK_CHAN:   rd_next = ch_rdata[32*int'(dec.chan) +: 32];
      default:   rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      reg_rdata <= '0;
    else if (reg_re) reg_rdata <= rd_next;
  end

  // R10: re-arm pulses only in the first enabled cycle
  p_rearm_edge_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (|ch_rearm) |-> (timer_enable && !$past(timer_enable)));

  // R8: at most one channel window selected
  p_sel_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ch_sel));

  // R9: channel writes always land on an existing channel
  p_we_target_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ch_we |-> $onehot(ch_sel));

  // R9: unmapped writes leave the control bits untouched
  p_drop_ctrl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && dec.kind == RK_NONE) |=> $stable(ctrl_q));

  // R5: counter loads are refused while running
  p_load_halted_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_load_lo || cnt_load_hi) |-> !timer_enable);
endmodule

// File: tb/tb_evt_timer_core.sv
`timescale 1ns/1ps
module tb_evt_timer_core;
  localparam int          NCH = 3;
  localparam logic [31:0] PFS = 32'd10_000_000;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             tick_en = 1'b0;
  logic [9:0]       reg_addr = '0;
  logic [31:0]      reg_wdata = '0;
  logic             reg_we = 1'b0;
  logic             reg_re = 1'b0;
  logic [31:0]      reg_rdata;
  logic [NCH-1:0]   ch_sel;
  logic [4:0]       ch_sub;
  logic [31:0]      ch_wdata;
  logic             ch_we;
  logic             ch_re;
  logic [32*NCH-1:0] ch_rdata;
  logic [NCH-1:0]   ch_cmp_max = '0;
  logic [NCH-1:0]   ch_event = '0;
  logic [NCH-1:0]   ch_rearm;
  logic [NCH-1:0]   irq_ack;
  logic [63:0]      count_out;
  logic             timer_enable;
  logic             legacy_route;

  int errors = 0;
  int checks = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        re_seen = 1'b0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  evt_timer_core #(.NUM_CH(NCH), .PERIOD_FS(PFS)) dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_re(reg_re),
    .reg_rdata(reg_rdata), .ch_sel(ch_sel), .ch_sub(ch_sub), .ch_wdata(ch_wdata),
    .ch_we(ch_we), .ch_re(ch_re), .ch_rdata(ch_rdata), .ch_cmp_max(ch_cmp_max),
    .ch_event(ch_event), .ch_rearm(ch_rearm), .irq_ack(irq_ack),
    .count_out(count_out), .timer_enable(timer_enable), .legacy_route(legacy_route)
  );

  // channel model: data identifies channel and sub-offset
  always_comb begin
    for (int i = 0; i < NCH; i++)
      ch_rdata[32*i +: 32] = {16'hC0DE, 8'(i), 3'b000, ch_sub};
  end

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: scoreboard for register reads
  always @(posedge clk) re_seen <= reg_re;
  always @(negedge clk) begin
    if (re_seen && exp_q.size() > 0) begin
      automatic logic [31:0] e = exp_q.pop_front();
      automatic string t = tag_q.pop_front();
      chk(t, {32'b0, reg_rdata}, {32'b0, e});
    end
  end

  // driver tasks start and end at a falling edge
  task automatic bus_wr(logic [9:0] a, logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic bus_rd(logic [9:0] a, logic [31:0] e, string tag);
    reg_addr = a; reg_re = 1'b1;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk);
    reg_re = 1'b0;
  endtask

  task automatic ticks(int n);
    for (int k = 0; k < n; k++) begin
      tick_en = 1'b1;
      @(negedge clk);
    end
    tick_en = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 reset state
    chk("R11 count", count_out, 64'd0);
    chk("R11 ctrl", {62'b0, legacy_route, timer_enable}, 64'd0);
    chk("R11 rearm/ack", {58'b0, ch_rearm, irq_ack}, 64'd0);
    chk("R11 rdata", {32'b0, reg_rdata}, 64'd0);
    bus_rd(10'h010, 32'h0, "R3 ctrl reset");
    bus_rd(10'h020, 32'h0, "R11 status reset");

    // R1 / R2 capability
    bus_rd(10'h000, 32'h8086A201, "R1 cap low");
    bus_rd(10'h004, PFS, "R2 cap high");
    bus_wr(10'h000, 32'h0);
    bus_wr(10'h004, 32'h0);
    bus_rd(10'h000, 32'h8086A201, "R2 cap low after write");
    bus_rd(10'h004, PFS, "R2 cap high after write");

    // R3 masked control, R12 outputs
    bus_wr(10'h010, 32'hFFFF_FFFC);
    bus_rd(10'h010, 32'h0, "R3 upper bits ignored");
    bus_wr(10'h010, 32'h2);
    bus_rd(10'h010, 32'h2, "R3 legacy bit");
    chk("R12 legacy_route", {63'b0, legacy_route}, 64'd1);
    chk("R12 timer_enable", {63'b0, timer_enable}, 64'd0);
    chk("R10 no rearm on legacy write", {61'b0, ch_rearm}, 64'd0);
    bus_wr(10'h010, 32'h0);

    // R5 half loads while halted
    bus_wr(10'h0F0, 32'hFFFF_FFFE);
    bus_wr(10'h0F4, 32'h0000_0005);
    chk("R5 load both halves", count_out, 64'h5_FFFF_FFFE);
    bus_wr(10'h0F4, 32'h0000_0007);
    chk("R5 low half kept", count_out, 64'h7_FFFF_FFFE);
    bus_rd(10'h0F0, 32'hFFFF_FFFE, "R5 read low");
    bus_rd(10'h0F4, 32'h0000_0007, "R5 read high");
    bus_wr(10'h0F4, 32'h0000_0005);

    // R4 frozen while disabled
    ticks(5);
    chk("R4 frozen", count_out, 64'h5_FFFF_FFFE);

    // R10 rearm on enable rise
    ch_cmp_max = 3'b010;
    bus_wr(10'h010, 32'h1);
    chk("R10 rearm pulse", {61'b0, ch_rearm}, 64'h5);
    chk("R12 enable out", {63'b0, timer_enable}, 64'd1);
    @(negedge clk);
    chk("R10 rearm single cycle", {61'b0, ch_rearm}, 64'd0);
    bus_wr(10'h010, 32'h1);
    chk("R10 no rearm when already on", {61'b0, ch_rearm}, 64'd0);

    // R4 carry across halves; no tick means hold
    ticks(3);
    chk("R4 carry", count_out, 64'h6_0000_0001);
    repeat (2) @(negedge clk);
    chk("R4 hold without tick", count_out, 64'h6_0000_0001);
    bus_wr(10'h0F0, 32'h0);
    bus_rd(10'h0F0, 32'h0000_0001, "R5 load dropped while running");
    bus_rd(10'h0F4, 32'h0000_0006, "R5 live high");

    // R6 status set and write-one clear
    ch_event = 3'b101;
    @(negedge clk);
    ch_event = 3'b000;
    bus_rd(10'h020, 32'h5, "R6 status set");
    bus_wr(10'h020, 32'h0);
    bus_rd(10'h020, 32'h5, "R6 write zero no effect");
    bus_wr(10'h020, 32'h4);
    chk("R6 ack pulse", {61'b0, irq_ack}, 64'h4);
    bus_rd(10'h020, 32'h1, "R6 after clear");
    chk("R6 ack single cycle", {61'b0, irq_ack}, 64'd0);
    // set beats clear on the same bit
    ch_event = 3'b010;
    bus_wr(10'h020, 32'h2);
    ch_event = 3'b000;
    bus_rd(10'h020, 32'h3, "R6 set wins over clear");

    // R7 disable flushes status
    bus_wr(10'h010, 32'h0);
    chk("R7 flush ack", {61'b0, irq_ack}, 64'h3);
    chk("R10 no rearm on disable", {61'b0, ch_rearm}, 64'd0);
    bus_rd(10'h020, 32'h0, "R7 status cleared");
    ch_event = 3'b111;
    @(negedge clk);
    ch_event = 3'b000;
    bus_rd(10'h020, 32'h0, "R7 no set while disabled");

    // R8 channel windows
    reg_addr = 10'h148; reg_wdata = 32'hA5A5_0001; reg_we = 1'b1;
    #1;
    chk("R8 sel ch2", {61'b0, ch_sel}, 64'h4);
    chk("R8 sub", {59'b0, ch_sub}, 64'h8);
    chk("R8 we/wdata", {31'b0, ch_we, ch_wdata}, {31'b0, 1'b1, 32'hA5A5_0001});
    @(negedge clk);
    reg_we = 1'b0;
    bus_rd(10'h124, 32'hC0DE_0104, "R8 read ch1 sub4");
    bus_rd(10'h100, 32'hC0DE_0000, "R8 read ch0 sub0");

    // R9 unmapped offsets
    reg_addr = 10'h160; reg_wdata = 32'h1; reg_we = 1'b1;
    #1;
    chk("R9 no sel/we beyond channels", {60'b0, ch_we, ch_sel}, 64'd0);
    @(negedge clk);
    reg_we = 1'b0;
    bus_rd(10'h160, 32'h0, "R9 read ch3");
    bus_rd(10'h008, 32'h0, "R9 read reserved");
    bus_wr(10'h014, 32'hFFFF_FFFF);
    bus_wr(10'h011, 32'hFFFF_FFFF);
    bus_rd(10'h010, 32'h0, "R9 ctrl unchanged");
    chk("R9 count unchanged", count_out, 64'h6_0000_0001);

    @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(negedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule